// File: doc/BRIEF.md
# Bilinear Texture Filter

This block takes one texture coordinate pair (U, V) in unsigned 10.6 fixed point, together with a mip level, the base texture width and height, and a table of per-level base addresses. It returns one bilinearly filtered colour with separate red, green and blue channels. It derives the four neighbouring texels and clamps them to the edge of the level's texel grid. It reads the four texels one per cycle through a 32-bit synchronous read port that has a fixed one-cycle latency. It then weights each texel colour by its share of the 6-bit fractions and sums the four.

A single-cycle `start` is taken on a rising edge only while `ready` is high. After that, `ready` stays low for three cycles, so the unit accepts at most one pixel every four cycles. Two pixels overlap in the pipeline, and each keeps its own coordinates, addresses and weights. The stages are: coordinate generation (1 cycle), address and weight generation with the texel reads (3 cycles), multiplication (3 cycles) and accumulation with final scaling (1 cycle). A result is announced by a single-cycle `outValid` pulse eight edges after the accepting edge.

Top module: `bilin_tex_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `ready` is 1 and both `outValid` and `memReq` are 0.
- R2: `start` is taken only on an edge where `ready` is high. After an acceptance, `ready` is low for exactly three cycles and then high again. A `start` seen while `ready` is low is ignored and produces no reads and no result.
- R3: Take the cycle in which an accepted `start` was high as cycle c. `memReq` is then high in cycles c+2 to c+5. The texels are requested in this order: (x0,y0), (x1,y0), (x0,y1), (x1,y1).
- R4: Each texel address equals (base_L + y*lw + x) mod 2^20. base_L is `levelBase[20*L+19 : 20*L]` for mip level L.
- R5: The integer coordinate ui is u[15:6]. Then x0 = min(ui, lw-1) and x1 = min(ui+1, lw-1). y0 and y1 follow the same rule from v[15:6] and lh.
- R6: Let fu = u[5:0] and fv = v[5:0]. The weights are (64-fu)(64-fv) for (x0,y0), fu(64-fv) for (x1,y0), (64-fu)fv for (x0,y1) and fu*fv for (x1,y1). Each output channel is the weighted sum of the four texel channels, shifted right by 12 and saturated to 255.
- R7: For an accepted `start` in cycle c, `outValid` is high in cycle c+9 only and carries that pixel's result. Outputs keep their value until the next result.
- R8: Read data is taken in the cycle after its request. Red is bits 23:16, green is bits 15:8 and blue is bits 7:0. Bits 31:24 have no effect on the result.
- R9: Pixels accepted every four cycles each produce the same addresses and results as they would alone.
- R10: The level dimensions are lw = texWidth >> L and lh = texHeight >> L, with a result of 0 raised to 1.
- R11: u, v, level, texWidth, texHeight and levelBase are used only at the accepting edge. Changes to them in later cycles do not alter that pixel's reads or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to filter one pixel |
| ready | output | 1 | High when `start` will be accepted |
| u | input | 16 | Horizontal coordinate, unsigned 10.6 |
| v | input | 16 | Vertical coordinate, unsigned 10.6 |
| level | input | 3 | Mip level index |
| texWidth | input | 11 | Texture width at level 0 |
| texHeight | input | 11 | Texture height at level 0 |
| levelBase | input | 160 | Eight 20-bit base addresses, level L at bits 20L+19:20L |
| memReq | output | 1 | Texel read request |
| memAddr | output | 20 | Texel read address |
| memRdata | input | 32 | Texel word, valid the cycle after its request |
| outValid | output | 1 | Single-cycle result strobe |
| outR | output | 8 | Filtered red |
| outG | output | 8 | Filtered green |
| outB | output | 8 | Filtered blue |

## Verification
Each result is due at fixed offsets from the cycle c in which an accepted `start` was driven. The four read requests and their addresses fall in cycles c+2 to c+5, `ready` is low in cycles c+1 to c+3, and the filtered colour with `outValid` appears in cycle c+9. The reference model enters every expectation into a table keyed by the absolute cycle number. On every falling edge it compares `ready`, `memReq`, `memAddr`, `outValid` and the colour against the entry for that cycle. A missing or early event is therefore caught in the cycle where it occurs. The stimulus covers edge clamping, zero fractions, collapsed level dimensions, address wrap, `start` held high for many cycles, and scrambled inputs between acceptances.

// File: rtl/bilin_pkg.sv
package bilin_pkg;

  // Strobes from the sequencer to the datapath, one bit per pipeline action.
  typedef struct packed {
    logic       ldCoord;   // capture inputs, clamp neighbours
    logic       ldAddr;    // build row addresses and weights
    logic       issue;     // one texel read this cycle
    logic [1:0] texSel;    // which of the four texels
    logic       mulEn;     // scale returned texel by its weight
    logic       accEn;     // add product into running sum
    logic       accFirst;  // first product of a pixel: load, not add
    logic       outLd;     // scale and saturate into the result
  } bilinStrobe_t;

  localparam int TEXELS = 4;

endpackage

// File: rtl/bilin_ctrl.sv
module bilin_ctrl
  import bilin_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output logic         ready,
  output bilinStrobe_t st,
  output logic         outValid
);

  localparam int GAP    = TEXELS;
  localparam int HOLD_W = $clog2(GAP);
  localparam int LAST   = 2 * GAP;          // token index of the result cycle

  logic              accept;
  logic [LAST:0]     tokQ;                  // tokQ[k] high k+1 cycles after accept
  logic [HOLD_W-1:0] holdCnt;

  assign ready  = (holdCnt == '0);
  assign accept = start && ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tokQ    <= '0;
      holdCnt <= '0;
    end else begin
      tokQ <= {tokQ[LAST-1:0], accept};
      if (accept)
        holdCnt <= HOLD_W'(GAP - 1);
      else if (holdCnt != '0)
        holdCnt <= holdCnt - HOLD_W'(1);
    end
  end

  always_comb begin
    st          = '0;
    st.ldCoord  = accept;
    st.ldAddr   = tokQ[0];
    st.issue    = |tokQ[GAP:1];
    st.mulEn    = |tokQ[GAP+1:2];
    st.accEn    = |tokQ[GAP+2:3];
    st.accFirst = tokQ[3];
    st.outLd    = tokQ[LAST-1];
    for (int k = 0; k < GAP; k++)
      if (tokQ[k+1]) st.texSel = 2'(k);
  end

  assign outValid = tokQ[LAST];

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && ready) |=> !ready);

  // R3
  tex_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.issue && st.texSel != 2'd3) |=>
      (st.issue && st.texSel == $past(st.texSel) + 2'd1));

  // R3
  tex_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.issue && st.texSel == 2'd3) |=> (!st.issue || st.texSel == 2'd0));

  // R7
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R9
  one_pixel_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tokQ[GAP:1]));

endmodule

// File: rtl/bilin_datapath.sv
module bilin_datapath
  import bilin_pkg::*;
#(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 6,
  parameter int LVL_W  = 3,
  parameter int DIM_W  = 11,
  parameter int ADDR_W = 20,
  parameter int CH_W   = 8,
  parameter int WORD_W = 32,
  localparam int COORD_W = INT_W + FRAC_W,
  localparam int NUM_LVL = 1 << LVL_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bilinStrobe_t              st,
  input  logic [COORD_W-1:0]        u,
  input  logic [COORD_W-1:0]        v,
  input  logic [LVL_W-1:0]          level,
  input  logic [DIM_W-1:0]          texWidth,
  input  logic [DIM_W-1:0]          texHeight,
  input  logic [NUM_LVL*ADDR_W-1:0] levelBase,
  input  logic [WORD_W-1:0]         memRdata,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [CH_W-1:0]           outR,
  output logic [CH_W-1:0]           outG,
  output logic [CH_W-1:0]           outB
);

  localparam int EXT_W  = ((DIM_W > INT_W) ? DIM_W : INT_W) + 1;
  localparam int WT_W   = 2 * (FRAC_W + 1);
  localparam int PROD_W = CH_W + WT_W;
  localparam int ACC_W  = PROD_W + 2;
  localparam int SHIFT  = 2 * FRAC_W;
  localparam int CHANS  = 3;
  localparam logic [ACC_W-1:0] CH_MAX  = ACC_W'((1 << CH_W) - 1);
  localparam logic [ACC_W-1:0] ACC_MAX = CH_MAX << SHIFT;
  localparam logic [FRAC_W:0]  ONE     = (FRAC_W + 1)'(1 << FRAC_W);

  // ---------------- coordinate generation ----------------
  logic [DIM_W-1:0] shW, shH, lwC, lhC;
  logic [EXT_W-1:0] uiE, viE, lwE, lhE, x0C, x1C, y0C, y1C;

  always_comb begin
    shW = texWidth  >> level;
    shH = texHeight >> level;
    lwC = (shW == '0) ? DIM_W'(1) : shW;
    lhC = (shH == '0) ? DIM_W'(1) : shH;
    uiE = EXT_W'(u[COORD_W-1:FRAC_W]);
    viE = EXT_W'(v[COORD_W-1:FRAC_W]);
    lwE = EXT_W'(lwC);
    lhE = EXT_W'(lhC);
    x0C = (uiE >= lwE) ? lwE - EXT_W'(1) : uiE;
    x1C = (uiE + EXT_W'(1) >= lwE) ? lwE - EXT_W'(1) : uiE + EXT_W'(1);
    y0C = (viE >= lhE) ? lhE - EXT_W'(1) : viE;
    y1C = (viE + EXT_W'(1) >= lhE) ? lhE - EXT_W'(1) : viE + EXT_W'(1);
  end

  logic [DIM_W-1:0]  x0Q, x1Q, y0Q, y1Q, lwQ;
  logic [FRAC_W-1:0] fuQ, fvQ;
  logic [ADDR_W-1:0] baseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      x0Q <= '0; x1Q <= '0; y0Q <= '0; y1Q <= '0; lwQ <= '0;
      fuQ <= '0; fvQ <= '0; baseQ <= '0;
    end else if (st.ldCoord) begin
      x0Q   <= DIM_W'(x0C);
      x1Q   <= DIM_W'(x1C);
      y0Q   <= DIM_W'(y0C);
      y1Q   <= DIM_W'(y1C);
      lwQ   <= lwC;
      fuQ   <= u[FRAC_W-1:0];
      fvQ   <= v[FRAC_W-1:0];
      baseQ <= levelBase[level*ADDR_W +: ADDR_W];
    end
  end

  // ---------------- address and weight generation ----------------
  logic [FRAC_W:0] fuE, fvE, invU, invV;
  logic [WT_W-1:0] wC [TEXELS];

  assign fuE  = {1'b0, fuQ};
  assign fvE  = {1'b0, fvQ};
  assign invU = ONE - fuE;
  assign invV = ONE - fvE;

  for (genvar k = 0; k < TEXELS; k++) begin : g_wt
    localparam bit HI_X = (k % 2) == 1;
    localparam bit HI_Y = k >= 2;
    assign wC[k] = WT_W'(HI_X ? fuE : invU) * WT_W'(HI_Y ? fvE : invV);
  end

  logic [ADDR_W-1:0] row0Q, row1Q, xa0Q, xa1Q;
  logic [WT_W-1:0]   wQ [TEXELS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      row0Q <= '0; row1Q <= '0; xa0Q <= '0; xa1Q <= '0;
      for (int k = 0; k < TEXELS; k++) wQ[k] <= '0;
    end else if (st.ldAddr) begin
      row0Q <= baseQ + ADDR_W'(y0Q) * ADDR_W'(lwQ);
      row1Q <= baseQ + ADDR_W'(y1Q) * ADDR_W'(lwQ);
      xa0Q  <= ADDR_W'(x0Q);
      xa1Q  <= ADDR_W'(x1Q);
      for (int k = 0; k < TEXELS; k++) wQ[k] <= wC[k];
    end
  end

  // texSel bit 0 picks the column, bit 1 picks the row
  assign memAddr = (st.texSel[1] ? row1Q : row0Q) + (st.texSel[0] ? xa1Q : xa0Q);

  logic [WT_W-1:0] wPipeQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         wPipeQ <= '0;
    else if (st.issue) wPipeQ <= wQ[st.texSel];
  end

  // ---------------- multiply, accumulate, scale ----------------
  logic unusedHiBits;
  assign unusedHiBits = ^memRdata[WORD_W-1:CHANS*CH_W];

  logic [CH_W-1:0] resQ [CHANS];

  for (genvar c = 0; c < CHANS; c++) begin : g_ch
    logic [PROD_W-1:0] prodQ;
    logic [ACC_W-1:0]  accQ;
    logic [ACC_W-1:0]  shifted;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prodQ <= '0;
      else if (st.mulEn)
        prodQ <= PROD_W'(memRdata[c*CH_W +: CH_W]) * PROD_W'(wPipeQ);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) accQ <= '0;
      else if (st.accEn)
        accQ <= st.accFirst ? ACC_W'(prodQ) : accQ + ACC_W'(prodQ);
    end

    assign shifted = accQ >> SHIFT;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resQ[c] <= '0;
      else if (st.outLd)
        resQ[c] <= (shifted > CH_MAX) ? '1 : shifted[CH_W-1:0];
    end

    // R6
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      st.outLd |-> (accQ <= ACC_MAX));
  end

  assign outB = resQ[0];
  assign outG = resQ[1];
  assign outR = resQ[2];

  // R5
  clamp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.ldAddr |-> (x1Q < lwQ) && (x0Q <= x1Q) && (y0Q <= y1Q));

endmodule

// File: rtl/bilin_tex_filter.sv
module bilin_tex_filter
  import bilin_pkg::*;
#(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 6,
  parameter int LVL_W  = 3,
  parameter int DIM_W  = 11,
  parameter int ADDR_W = 20,
  parameter int CH_W   = 8,
  parameter int WORD_W = 32,
  localparam int COORD_W = INT_W + FRAC_W,
  localparam int NUM_LVL = 1 << LVL_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  output logic                      ready,
  input  logic [COORD_W-1:0]        u,
  input  logic [COORD_W-1:0]        v,
  input  logic [LVL_W-1:0]          level,
  input  logic [DIM_W-1:0]          texWidth,
  input  logic [DIM_W-1:0]          texHeight,
  input  logic [NUM_LVL*ADDR_W-1:0] levelBase,
  output logic                      memReq,
  output logic [ADDR_W-1:0]         memAddr,
  input  logic [WORD_W-1:0]         memRdata,
  output logic                      outValid,
  output logic [CH_W-1:0]           outR,
  output logic [CH_W-1:0]           outG,
  output logic [CH_W-1:0]           outB
);

  bilinStrobe_t st;

  bilin_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .ready    (ready),
    .st       (st),
    .outValid (outValid)
  );

  bilin_datapath #(
    .INT_W (INT_W), .FRAC_W (FRAC_W), .LVL_W (LVL_W), .DIM_W (DIM_W),
    .ADDR_W(ADDR_W), .CH_W (CH_W), .WORD_W (WORD_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .u         (u),
    .v         (v),
    .level     (level),
    .texWidth  (texWidth),
    .texHeight (texHeight),
    .levelBase (levelBase),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .outR      (outR),
    .outG      (outG),
    .outB      (outB)
  );

  assign memReq = st.issue;

endmodule

// File: tb/bilin_tex_filter_tb_top.sv
module bilin_tex_filter_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         ready;
  logic [15:0]  u = '0, v = '0;
  logic [2:0]   level = '0;
  logic [10:0]  texWidth = '0, texHeight = '0;
  logic [159:0] levelBase = '0;
  logic         memReq;
  logic [19:0]  memAddr;
  logic [31:0]  memRdata = '0;
  logic         outValid;
  logic [7:0]   outR, outG, outB;

  bilin_tex_filter dut_i (
    .clk(clk), .rstN(rstN), .start(start), .ready(ready),
    .u(u), .v(v), .level(level), .texWidth(texWidth), .texHeight(texHeight),
    .levelBase(levelBase), .memReq(memReq), .memAddr(memAddr),
    .memRdata(memRdata), .outValid(outValid),
    .outR(outR), .outG(outG), .outB(outB)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  int lastAcc = -100;
  int junk = 32'h1234_5678;
  logic [159:0] baseGood;

  bit    expReq [int];
  int    expAddr[int];
  string reqTag [int];
  int    expRgb [int];
  string outTag [int];

  // Texel memory content, computed from the address; bits 31:24 are noise.
  function automatic int texWord(int a);
    int r, g, b, h;
    r = (a * 7 + 3) & 255;
    g = (a * 29) & 255;
    b = (a ^ (a >> 4)) & 255;
    h = (a * 3 + 91) & 255;
    return (h << 24) | (r << 16) | (g << 8) | b;
  endfunction

  always @(posedge clk) if (memReq) memRdata <= texWord(int'(memAddr));

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s cycle=%0d actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic checkCycle();
    bit rdyExp, reqExp, outExp;
    rdyExp = (rstN == 1'b0) || (cyc >= lastAcc + 4);
    reqExp = expReq.exists(cyc);
    outExp = expRgb.exists(cyc);
    chk(ready === rdyExp, "R2", "ready", int'(ready), int'(rdyExp));
    chk(memReq === reqExp, "R3", "memReq", int'(memReq), int'(reqExp));
    if (reqExp)
      chk(int'(memAddr) == expAddr[cyc], reqTag[cyc], "memAddr", int'(memAddr), expAddr[cyc]);
    chk(outValid === outExp, "R7", "outValid", int'(outValid), int'(outExp));
    if (outExp)
      chk({8'd0, outR, outG, outB} == expRgb[cyc], outTag[cyc], "rgb",
          int'({outR, outG, outB}), expRgb[cyc]);
  endtask

  // Reference: fill the expectation tables for a pixel accepted in cycle c.
  task automatic modelPixel(int c, int uu, int vv, int ll, int ww, int hh, string tag);
    int lw, lh, ui, vi, fu, fv, base;
    int xs[2], ys[2], a[4], w[4], sum, res, rgb;
    lw = ww >> ll; if (lw == 0) lw = 1;
    lh = hh >> ll; if (lh == 0) lh = 1;
    ui = (uu >> 6) & 1023; vi = (vv >> 6) & 1023;
    fu = uu & 63; fv = vv & 63;
    xs[0] = (ui < lw) ? ui : lw - 1;  xs[1] = (ui + 1 < lw) ? ui + 1 : lw - 1;
    ys[0] = (vi < lh) ? vi : lh - 1;  ys[1] = (vi + 1 < lh) ? vi + 1 : lh - 1;
    base = int'(baseGood[ll*20 +: 20]);
    for (int k = 0; k < 4; k++) begin
      a[k] = (base + ys[k/2] * lw + xs[k%2]) & 32'hFFFFF;
      expReq[c+2+k]  = 1'b1;
      expAddr[c+2+k] = a[k];
      reqTag[c+2+k]  = {"R4 R5 R10 ", tag};
    end
    w[0] = (64 - fu) * (64 - fv); w[1] = fu * (64 - fv);
    w[2] = (64 - fu) * fv;        w[3] = fu * fv;
    rgb = 0;
    for (int ch = 2; ch >= 0; ch--) begin
      sum = 0;
      for (int k = 0; k < 4; k++) sum += w[k] * ((texWord(a[k]) >> (8 * ch)) & 255);
      res = sum >> 12;
      if (res > 255) res = 255;
      rgb = (rgb << 8) | res;
    end
    expRgb[c+9] = rgb;
    outTag[c+9] = {"R6 R8 ", tag};
  endtask

  task automatic step(bit st, int uu, int vv, int ll, int ww, int hh, string tag);
    @(negedge clk);
    checkCycle();
    junk = junk * 1103515245 + 12345;
    if (st) begin
      start = 1'b1; u = uu[15:0]; v = vv[15:0]; level = ll[2:0];
      texWidth = ww[10:0]; texHeight = hh[10:0]; levelBase = baseGood;
      if (cyc >= lastAcc + 4) begin
        lastAcc = cyc;
        modelPixel(cyc, uu, vv, ll, ww, hh, tag);
      end
    end else begin
      // R11: scramble every sampled input outside the accepting cycle
      start = 1'b0; u = junk[15:0]; v = junk[31:16]; level = junk[6:4];
      texWidth = junk[20:10]; texHeight = junk[27:17];
      levelBase = baseGood ^ {5{junk}};
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic pix(int ui, int fu, int vi, int fv, int ll, int ww, int hh, string tag);
    step(1'b1, (ui << 6) | fu, (vi << 6) | fv, ll, ww, hh, tag);
    idle(3);
  endtask

  initial begin
    for (int l = 0; l < 8; l++) baseGood[l*20 +: 20] = 20'(l * 32'h1_9000 + 32'h300);
    baseGood[7*20 +: 20] = 20'hFFFFE;   // level 7 wraps the address space
    baseGood[6*20 +: 20] = 20'hFFF80;
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(ready === 1'b1, "R1", "ready", int'(ready), 1);
      chk(memReq === 1'b0, "R1", "memReq", int'(memReq), 0);
      chk(outValid === 1'b0, "R1", "outValid", int'(outValid), 0);
    end
    rstN = 1'b1;
    idle(2);
    pix(5, 20, 7, 40, 0, 64, 64, "interior");           idle(10);
    pix(63, 32, 63, 10, 0, 64, 64, "right-bottom edge"); idle(10);
    pix(100, 5, 200, 63, 0, 64, 64, "beyond grid");      idle(10);
    pix(3, 0, 9, 0, 0, 64, 64, "zero fractions");        idle(10);
    pix(24, 63, 9, 63, 2, 100, 40, "level 2 clamp");     idle(10);
    pix(0, 33, 0, 17, 7, 100, 100, "level 7 collapsed"); idle(10);
    pix(1, 50, 2, 60, 6, 1024, 1024, "address wrap");    idle(10);
    pix(2, 63, 2, 63, 0, 256, 256, "max fractions");     idle(10);
    // R9: back-to-back pixels every four cycles
    for (int i = 0; i < 6; i++) pix(i * 11, i * 9, i * 5, 63 - i * 7, i % 3, 500, 300, "R9 burst");
    idle(10);
    // R2: start held high every cycle; only one in four is taken
    for (int i = 0; i < 17; i++)
      step(1'b1, (i * 37) << 4, (i * 53) << 3, i % 4, 700, 600, "R2 held start");
    idle(12);
    for (int i = 0; i < 30; i++) begin
      junk = junk * 1103515245 + 12345;
      step(1'b1, junk[15:0], junk[31:16], junk[2:0] % 5, 64 + (i * 67) % 1900,
           16 + (i * 41) % 1000, "R9 R11 mixed");
      idle(3 + (i % 3));
    end
    idle(12);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule